// File: doc/BRIEF.md
# Eight-to-one half-band decimation chain

This block sits after a delta-sigma modulator and its word-level front end. It accepts one signed sample on every clock and runs the stream through three half-band FIR stages in series. Each stage keeps every second output, so one result leaves the chain for every eight input words. All three stages use the same 7-tap kernel, (-1, 0, 9, 16, 9, 0, -1)/32. Each stage rounds its accumulator and saturates it back to the data width.

The per-stage phase bits together form the chain's sequencer. A synchronous `sync` input, or `init`, which acts the same way, clears the sequencer and every stage's history. When several copies run from one master clock and receive the same pulse, they emit their words on the same cycle. A `settled` flag drops on a sync or a reset. It rises again once the last stage's window holds only samples taken after that event.

Top module: `hb_decim8`

## Requirements
- R1: Each stage computes acc = 16*w3 + 9*(w2+w4) - (w0+w6), where w0 is the newest input sample and w6 is the sixth older one. Its output is floor((acc+16)/32), saturated to the signed range of W bits. Samples from before the last sync count as zero.
- R2: Each stage emits an output only on its 2nd, 4th, 6th, ... input after a sync, which halves its rate. Its valid strobe is never high on two consecutive cycles.
- R3: The chain takes one input word on every clock. In steady state `out_vld` pulses once every 8 cycles.
- R4: Let E0 be the edge at which sync is sampled high, and let x_k be the word sampled at edge Ek (k>=1). The n-th output is registered at edge E(8n+2) and is visible on `out_d` with `out_vld` high until the next edge.
- R5: While sync is sampled high, the sequencer and all stage state stay at zero. `out_vld` stays 0 and `out_d` reads 0.
- R6: A one-cycle sync pulse is enough. Decimation resumes at the first edge where sync is sampled low, and the word sampled at that edge is x_1.
- R7: Sampling `init` high has exactly the same effect as sampling `sync` high.
- R8: `settled` is 0 after a sync, an init or a reset. It is 1 from edge E34 onward, which is the edge of the 4th output, and it stays 1 until the next sync, init or reset.
- R9: Synchronous active-low `rst_n` clears the block like a sync: `out_vld`=0, `out_d`=0, `settled`=0.
- R10: Once settled, a constant input A gives output A (unity DC gain). An input alternating +A/-A each cycle gives output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input word per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Synchronous sequencer clear, active high |
| init | input | 1 | Initialisation request; acts as sync |
| in_d | input | W (16) | Signed input sample |
| out_d | output | W (16) | Signed decimated output, held between strobes |
| out_vld | output | 1 | One-cycle strobe for a new output word |
| settled | output | 1 | High once the pipeline has refilled after a sync |

## Verification
The chain is driven with four input patterns:
- A constant at both full-scale extremes, which exposes errors in gain and rounding.
- A full-rate alternating sequence, which must cancel to zero and so exposes any wrong tap or a wrong retained phase.
- A ramp, which separates a correct group delay from an off-by-one window.
- A burst of five highs and three lows at full scale, which drives the stages into saturation.

Every output is compared with an independent bit-level model indexed by R4's edge numbering. This makes a sequencer shifted by one cycle fail on both timing and value. Held sync, init and mid-run reset are tried separately to show that they clear the state and realign the chain.

// File: rtl/hbd_pkg.sv
// Package hbd_pkg
// Shared constants and elaboration-time helpers for the half-band decimator.
// Assumes every stage uses the same 7-tap kernel (-1,0,9,16,9,0,-1)/32.
package hbd_pkg;
    localparam int HB_TAPS  = 7;             // kernel length
    localparam int HB_HIST  = HB_TAPS - 1;   // stored past samples
    localparam int HB_SHIFT = 5;             // kernel gain is 2**HB_SHIFT
    localparam int HB_GUARD = 7;             // accumulator guard bits

    // Edge index after a sync at which the last stage's window first holds
    // only post-sync data: first output edge plus (taps+1)/2-1 output periods.
    function automatic int settle_edges(input int n_stg, input int taps);
        int f;
        f = 2;
        for (int s = 2; s <= n_stg; s++) f = f + 1 + (1 << (s - 1));
        return f + (1 << n_stg) * ((taps + 1) / 2 - 1);
    endfunction
endpackage

// File: rtl/hb_stage.sv
// Module hb_stage
// One half-band decimate-by-two stage. It shifts in a sample on every in_vld,
// toggles its phase bit, and on the odd phase registers the rounded, saturated
// kernel output. Assumes in_vld never comes on two consecutive cycles after
// stage one. clr acts like reset.
module hb_stage
    import hbd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_d,
    output logic                out_vld,
    output logic signed [W-1:0] out_d
);
    localparam int AW = W + HB_GUARD;
    localparam logic signed [AW-1:0] MAXV = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [AW-1:0] RND_HALF = AW'(1) <<< (HB_SHIFT - 1);

    logic signed [W-1:0]  hist [HB_HIST];
    logic                 phase;
    logic signed [AW-1:0] win  [HB_TAPS];
    logic signed [AW-1:0] near_sum, acc, rnd;
    logic signed [W-1:0]  sat_d;

    // Build the sign-extended window with the incoming sample as newest tap.
    always_comb begin
        win[0] = {{(AW-W){in_d[W-1]}}, in_d};
        for (int i = 1; i < HB_TAPS; i++)
            win[i] = {{(AW-W){hist[i-1][W-1]}}, hist[i-1]};
    end

    // Shift-add kernel, round half up, then saturate to W bits.
    always_comb begin
        near_sum = win[2] + win[4];
        acc      = (win[3] <<< 4) + (near_sum <<< 3) + near_sum - win[0] - win[6];
        rnd      = (acc + RND_HALF) >>> HB_SHIFT;
        if (rnd > MAXV)      sat_d = MAXV[W-1:0];
        else if (rnd < MINV) sat_d = MINV[W-1:0];
        else                 sat_d = rnd[W-1:0];
    end

    // History shift, phase toggle and decimated output register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < HB_HIST; i++) hist[i] <= '0;
            phase   <= 1'b0;
            out_vld <= 1'b0;
            out_d   <= '0;
        end else begin
            out_vld <= in_vld && phase;
            if (in_vld) begin
                hist[0] <= in_d;
                for (int i = 1; i < HB_HIST; i++) hist[i] <= hist[i-1];
                phase <= ~phase;
                if (phase) out_d <= sat_d;
            end
        end
    end

    // R2
    dec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld)
        else $error("stage strobe on consecutive cycles");

    // R2
    vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld) && !$past(clr))
        else $error("stage strobe without an input");
endmodule

// File: rtl/settle_tracker.sv
// Module settle_tracker
// Counts edges since the last clear and flags when LIMIT is reached.
// Assumes LIMIT > 0. The count saturates, so the flag stays high until cleared.
module settle_tracker #(
    parameter int LIMIT = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic settled
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Saturating edge counter, restarted by clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign settled = (cnt == LIM);

    // R8
    settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !clr) |=> settled)
        else $error("settled dropped without a clear");
endmodule

// File: rtl/hb_decim8.sv
// Module hb_decim8
// Top of the decimation chain: N_STG half-band stages in series, with a
// shared clear from sync or init, and a settle flag. Assumes one valid input
// word per clock. With the defaults the chain decimates by eight.
module hb_decim8
    import hbd_pkg::*;
#(
    parameter int W     = 16,
    parameter int N_STG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync,
    input  logic                init,
    input  logic signed [W-1:0] in_d,
    output logic signed [W-1:0] out_d,
    output logic                out_vld,
    output logic                settled
);
    localparam int DEC    = 1 << N_STG;
    localparam int SETTLE = settle_edges(N_STG, HB_TAPS);
    localparam int GW     = $clog2(DEC) + 2;

    logic                clr;
    logic                vld [N_STG+1];
    logic signed [W-1:0] dat [N_STG+1];

    assign clr    = sync | init;
    assign vld[0] = 1'b1;
    assign dat[0] = in_d;

    // One half-band stage per decimation step.
    for (genvar s = 0; s < N_STG; s++) begin : g_stage
        hb_stage #(.W(W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .in_vld (vld[s]),
            .in_d   (dat[s]),
            .out_vld(vld[s+1]),
            .out_d  (dat[s+1])
        );
    end

    settle_tracker #(.LIMIT(SETTLE)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .settled(settled)
    );

    assign out_vld = vld[N_STG];
    assign out_d   = dat[N_STG];

    // Checker state: cycles since the previous output strobe.
    logic [GW-1:0] gap;
    logic          seen;
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (out_vld) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    // R3
    out_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && seen) |-> gap == GW'(DEC - 1))
        else $error("output strobe period is not DEC");

    // R5
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (!out_vld && out_d == '0 && !settled))
        else $error("sync did not clear the chain");

    // R7
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!out_vld && out_d == '0 && !settled))
        else $error("init did not clear the chain");

    // R8
    settle_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> out_vld)
        else $error("settled rose off an output strobe");
endmodule

// File: tb/hb_decim8_bench.sv
`timescale 1ns/1ps
module hb_decim8_bench;
    localparam int W  = 16;
    localparam int NK = 120;
    localparam int NV = 6;
    localparam int NONE = -100000;
    // Vector table: pattern kind (0 DC, 1 alternating, 2 ramp, 3 burst 5 hi/3 lo),
    // amplitude, clear via init (1) or sync (0), expected steady output.
    localparam int VK [NV] = '{0,      0,      1,     2,    3,     0};
    localparam int VA [NV] = '{32767, -32768, 20000,  250, 32767, 1234};
    localparam int VI [NV] = '{0,      0,      0,     0,    0,     1};
    localparam int VE [NV] = '{32767, -32768,  0,   NONE, NONE,  1234};

    logic clk = 1'b0;
    logic rst_n = 1'b0, sync = 1'b0, init = 1'b0;
    logic signed [W-1:0] in_d = '0;
    logic signed [W-1:0] out_d;
    logic out_vld, settled;
    int tests = 0, fails = 0;
    int xs [0:NK], y1 [0:NK/2], y2 [0:NK/4], y3 [0:NK/8];

    always #2.5 clk = ~clk;

    hb_decim8 #(.W(W), .N_STG(3)) u_hb_decim8 (
        .clk(clk), .rst_n(rst_n), .sync(sync), .init(init), .in_d(in_d),
        .out_d(out_d), .out_vld(out_vld), .settled(settled));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hb(input int w0, w1, w2, w3, w4, w5, w6);
        int acc, r;
        acc = 16*w3 + 9*(w2 + w4) - (w0 + w6) + 0*(w1 + w5);
        r = (acc + 16) >>> 5;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int at(input int which, input int i);
        if (i < 1) return 0;
        case (which)
            0: return xs[i];
            1: return y1[i];
            default: return y2[i];
        endcase
    endfunction

    // Reference model from R1, R2 and R4: output j of a stage uses inputs 2j..2j-6.
    task automatic build(input int kind, input int amp);
        for (int k = 0; k <= NK; k++) begin
            case (kind)
                0: xs[k] = amp;
                1: xs[k] = (k % 2 == 1) ? amp : -amp;
                2: xs[k] = k * amp;
                default: xs[k] = (k % 8 < 5) ? amp : -amp;
            endcase
        end
        for (int j = 1; j <= NK/2; j++)
            y1[j] = hb(at(0,2*j), at(0,2*j-1), at(0,2*j-2), at(0,2*j-3), at(0,2*j-4), at(0,2*j-5), at(0,2*j-6));
        for (int j = 1; j <= NK/4; j++)
            y2[j] = hb(at(1,2*j), at(1,2*j-1), at(1,2*j-2), at(1,2*j-3), at(1,2*j-4), at(1,2*j-5), at(1,2*j-6));
        for (int j = 1; j <= NK/8; j++)
            y3[j] = hb(at(2,2*j), at(2,2*j-1), at(2,2*j-2), at(2,2*j-3), at(2,2*j-4), at(2,2*j-5), at(2,2*j-6));
    endtask

    task automatic run_vec(input int v);
        int n, last, serr;
        build(VK[v], VA[v]);
        @(negedge clk);
        if (VI[v] != 0) init = 1'b1; else sync = 1'b1;
        in_d = 16'sd4321;
        @(negedge clk);
        sync = 1'b0; init = 1'b0;
        check(!out_vld && out_d == 0 && !settled, VI[v] != 0 ? "R7 init clear" : "R5 sync clear", int'(out_d), 0);
        n = 0; last = 0; serr = 0;
        for (int k = 1; k <= NK; k++) begin
            in_d = W'(xs[k]);
            @(negedge clk);
            if (out_vld) begin
                n++;
                check(k == 8*n + 2, "R4 R6 output edge", k, 8*n + 2);
                if (n <= NK/8) check(int'(out_d) == y3[n], "R1 output value", int'(out_d), y3[n]);
                last = int'(out_d);
            end
            if (settled != (k >= 34)) serr++;
        end
        check(n == (NK - 2) / 8, "R2 R3 output count", n, (NK - 2) / 8);
        check(serr == 0, "R8 settled timing", serr, 0);
        if (VE[v] != NONE) check(last == VE[v], "R10 steady output", last, VE[v]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_vld && out_d == 0 && !settled, "R9 reset state", int'(out_d), 0);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) run_vec(v);

        // R5: sync held high keeps everything at zero.
        begin
            int herr;
            herr = 0;
            @(negedge clk);
            sync = 1'b1; in_d = 16'sd777;
            repeat (20) begin
                @(negedge clk);
                if (out_vld || out_d != 0 || settled) herr++;
            end
            sync = 1'b0;
            check(herr == 0, "R5 held sync", herr, 0);
        end

        // R9: mid-run reset clears outputs and settled.
        in_d = 16'sd9000;
        repeat (60) @(negedge clk);
        check(settled && out_d != 0, "R8 settled before reset", int'(settled), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_vld && out_d == 0 && !settled, "R9 mid-run reset", int'(out_d), 0);
        rst_n = 1'b1;
        run_vec(0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule